// File: doc/BRIEF.md
# Serial EEPROM Read and Protect Slave

This block is the slave side of a small serial EEPROM on a four-wire SPI-style port: an active-low select, a serial clock, a data input and a data output with an enable that models a high-impedance pin. The serial pins are sampled with the system clock, so the serial clock must run at least four times slower than `clk`. The block accepts a one-byte instruction and serves two commands. A sequential read streams bytes from an internal byte array for as long as serial clocks keep coming. A status write sets two block-protect bits.

The protect bits drive a range checker. It tells whether a byte address lies in the write-protected part of the array. A busy flag models the internal write cycle that follows an accepted status write. The array size is a parameter (128, 256 or 512 bytes). The array holds a fixed pattern from reset, because the byte-write path belongs to another block.

Top module: `serial_ee_slave`

## Requirements
- R1: After reset `spi_dout_oe`, `wr_busy` and `bp_state` are 0. Array byte `a` holds ((a*29+7) mod 256) XOR (A5h when a >= 256, else 0).
- R2: The first 8 `spi_din` bits after `spi_sel_n` falls are the instruction, taken MSB first on serial-clock rising edges. Any value matching 0000x011b is a read, and its bit 3 becomes address bit 8. The next 8 bits are address bits 7..0, MSB first.
- R3: Read data leaves MSB first, one bit per serial-clock falling edge, starting at the falling edge of the 16th clock. `spi_dout_oe` stays 0 during the instruction and the address, and while `spi_sel_n` is high.
- R4: After the 8th bit of a byte, the read address increments. From the last array byte it wraps to 0.
- R5: Address bits above the array size are ignored. With 128 bytes, bits 8 and 7 read as 0.
- R6: Raising `spi_sel_n` at any point ends the transfer. The next low period starts a new instruction.
- R7: Instruction 01h followed by 8 status bits sets `bp_state` to status bits 3:2. This happens only when `spi_sel_n` rises after exactly 16 serial clocks.
- R8: A status write that ends after fewer than 16 clocks, or that sees a 17th rising clock, leaves `bp_state` unchanged and does not start busy.
- R9: An accepted status write holds `wr_busy` at 1 for exactly `BUSY_CYCLES` clocks, starting on the clock after `spi_sel_n` rises.
- R10: A read or a status write whose instruction completes while `wr_busy` is 1 is rejected. `spi_dout_oe` stays 0 and `bp_state` is unchanged.
- R11: `wp_blocked` flags `wp_chk_addr` (masked to the array size). Value 00 flags nothing, 01 flags the top quarter, 10 flags the top half and 11 flags every address.
- R12: Any other instruction byte is ignored. `spi_dout_oe` stays 0 until `spi_sel_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sel_n | input | 1 | Serial select, active low |
| spi_clk | input | 1 | Serial clock |
| spi_din | input | 1 | Serial data into the device |
| spi_dout | output | 1 | Serial data out of the device |
| spi_dout_oe | output | 1 | Output drive enable (0 = high impedance) |
| wp_chk_addr | input | 9 | Byte address to test against the protected range |
| wp_blocked | output | 1 | High when a write to `wp_chk_addr` is not allowed |
| wr_busy | output | 1 | Internal write cycle in progress |
| bp_state | output | 2 | Current block-protect bits |

## Verification
The read path is exercised with start addresses every third location across the 512-byte space, two bytes each. Upper-half addresses check that opcode bit 3 carries address bit 8. A long stream starting near the top checks the wrap. A 128-byte instance on the same wires checks that high address bits are dropped. The protect checker is swept over all 512 addresses for each of the four protect values, which separates the quarter and half boundaries for both sizes. Status writes with 12, 16 and 17 clocks, commands issued during busy, an unknown opcode and a select raised in mid-byte separate the commit, reject and abort cases.

// File: rtl/serial_ee_pkg.sv
// Shared types, opcodes and the power-up array pattern for the serial EEPROM slave.
// Assumes the array never exceeds 512 bytes.
package serial_ee_pkg;

    typedef enum logic [2:0] {
        ST_CMD,     // receiving instruction bits
        ST_ADDR,    // receiving the low address byte
        ST_DATA,    // streaming array bytes
        ST_SRDATA,  // receiving status bits
        ST_SRWAIT,  // status complete, waiting for select to rise
        ST_IGNORE   // transaction dropped until deselect
    } see_state_e;

    localparam logic [7:0] OPC_READ_MASK = 8'hF7;
    localparam logic [7:0] OPC_READ      = 8'h03;
    localparam logic [7:0] OPC_SR_WRITE  = 8'h01;

    // Fixed content loaded into the array at reset.
    function automatic logic [7:0] init_byte(input int unsigned a);
        logic [7:0] v;
        v = 8'((a * 29 + 7) % 256);
        if (a >= 256) v = v ^ 8'hA5;
        return v;
    endfunction

endpackage

// File: rtl/serial_ee_edge.sv
// Single-edge detector on a slow input sampled by the system clock.
// RISING selects which edge gives a one-cycle pulse. IDLE_LVL is the level assumed at reset.
// Assumes the input is already synchronous to clk.
module serial_ee_edge #(
    parameter bit RISING   = 1'b1,
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);
    logic prev;

    // Keep the previous sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = sig & ~prev;
        end else begin : g_fall
            assign pulse = ~sig & prev;
        end
    endgenerate
endmodule

// File: rtl/serial_ee_protect.sv
// Write-protect range checker: maps the two protect bits onto the upper part of the array.
// Assumes the address is already masked to AW bits.
module serial_ee_protect #(
    parameter int AW = 9
) (
    input  logic [1:0]    bp,
    input  logic [AW-1:0] addr,
    output logic          blocked
);
    // Decode the protected span from the protect bits.
    always_comb begin
        unique case (bp)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = (addr[AW-1:AW-2] == 2'b11);
            2'b10:   blocked = addr[AW-1];
            default: blocked = 1'b1;
        endcase
    end

    // R11: the two extreme settings must not depend on the address.
    always_comb begin
        if (bp == 2'b11) a_r11_all_blocked: assert (blocked);
        if (bp == 2'b00) a_r11_none_blocked: assert (!blocked);
    end
endmodule

// File: rtl/serial_ee_slave.sv
// Serial EEPROM slave: decodes a one-byte instruction, serves sequential reads from an
// internal array and commits block-protect bits on a correctly framed status write.
// Assumes spi_* inputs are synchronous to clk, with serial clock phases of at least 2 clk.
module serial_ee_slave #(
    parameter int MEM_BYTES   = 512,
    parameter int BUSY_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sel_n,
    input  logic       spi_clk,
    input  logic       spi_din,
    output logic       spi_dout,
    output logic       spi_dout_oe,
    input  logic [8:0] wp_chk_addr,
    output logic       wp_blocked,
    output logic       wr_busy,
    output logic [1:0] bp_state
);
    import serial_ee_pkg::*;

    localparam int AW  = $clog2(MEM_BYTES);
    localparam int BCW = $clog2(BUSY_CYCLES + 1);

    see_state_e     state;
    logic [2:0]     bcnt;
    logic [2:0]     ocnt;
    logic [6:0]     shreg;
    logic           a8;
    logic [AW-1:0]  addr;
    logic [1:0]     sr_pend;
    logic [1:0]     bp;
    logic [BCW-1:0] busy_cnt;
    logic           q, q_oe;
    logic           sclk_rise, sclk_fall, sel_rise;
    logic [7:0]     nxt_byte;
    logic [8:0]     full_addr;
    logic [7:0]     rd_byte;
    logic [7:0]     mem [MEM_BYTES];

    serial_ee_edge #(.RISING(1'b1), .IDLE_LVL(1'b0)) u_sclk_rise (
        .clk(clk), .rst_n(rst_n), .sig(spi_clk), .pulse(sclk_rise));
    serial_ee_edge #(.RISING(1'b0), .IDLE_LVL(1'b0)) u_sclk_fall (
        .clk(clk), .rst_n(rst_n), .sig(spi_clk), .pulse(sclk_fall));
    serial_ee_edge #(.RISING(1'b1), .IDLE_LVL(1'b1)) u_sel_rise (
        .clk(clk), .rst_n(rst_n), .sig(spi_sel_n), .pulse(sel_rise));

    serial_ee_protect #(.AW(AW)) u_protect (
        .bp(bp), .addr(wp_chk_addr[AW-1:0]), .blocked(wp_blocked));

    // Assemble the byte completed by the current input bit and the raw 9-bit read address.
    always_comb begin
        nxt_byte  = {shreg, spi_din};
        full_addr = {a8, nxt_byte};
        rd_byte   = mem[addr];
    end

    // Array storage: loaded with the fixed pattern at reset, read-only afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= init_byte(i);
        end
    end

    // Transaction sequencer, output shifter, status commit and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            bcnt     <= '0;
            ocnt     <= '0;
            shreg    <= '0;
            a8       <= 1'b0;
            addr     <= '0;
            sr_pend  <= '0;
            bp       <= '0;
            busy_cnt <= '0;
            q        <= 1'b0;
            q_oe     <= 1'b0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (spi_sel_n) begin
                if (sel_rise && state == ST_SRWAIT) begin
                    bp       <= sr_pend;
                    busy_cnt <= BCW'(BUSY_CYCLES);
                end
                state <= ST_CMD;
                bcnt  <= '0;
                ocnt  <= '0;
                q_oe  <= 1'b0;
            end else if (sclk_rise) begin
                shreg <= nxt_byte[6:0];
                bcnt  <= bcnt + 1'b1;
                unique case (state)
                    ST_CMD: if (bcnt == 3'd7) begin
                        if (wr_busy) begin
                            state <= ST_IGNORE;
                        end else if ((nxt_byte & OPC_READ_MASK) == OPC_READ) begin
                            a8    <= nxt_byte[3];
                            state <= ST_ADDR;
                        end else if (nxt_byte == OPC_SR_WRITE) begin
                            state <= ST_SRDATA;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                    ST_ADDR: if (bcnt == 3'd7) begin
                        addr  <= full_addr[AW-1:0];
                        state <= ST_DATA;
                    end
                    ST_SRDATA: if (bcnt == 3'd7) begin
                        sr_pend <= nxt_byte[3:2];
                        state   <= ST_SRWAIT;
                    end
                    ST_SRWAIT: state <= ST_IGNORE;
                    default: ;
                endcase
            end else if (sclk_fall && state == ST_DATA) begin
                q    <= rd_byte[~ocnt];
                q_oe <= 1'b1;
                ocnt <= ocnt + 1'b1;
                if (ocnt == 3'd7) addr <= addr + 1'b1;
            end
        end
    end

    assign wr_busy     = (busy_cnt != '0);
    assign spi_dout    = q;
    assign spi_dout_oe = q_oe;
    assign bp_state    = bp;

    // R3: the output is released once select is high.
    a_r3_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel_n |=> !spi_dout_oe);
    // R3: the output drives only while data is streaming.
    a_r3_oe_only_data: assert property (@(posedge clk) disable iff (!rst_n)
        spi_dout_oe |-> state == ST_DATA);
    // R4: the address steps by one after the last bit of a byte.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !spi_sel_n && !sclk_rise && sclk_fall && ocnt == 3'd7)
        |=> addr == $past(addr) + 1'b1);
    // R7: the protect bits change only out of the commit wait state.
    a_r7_bp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_SRWAIT |=> $stable(bp));
    // R9: the busy timer counts down by one each clock.
    a_r9_busy_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt != '0 |=> busy_cnt == $past(busy_cnt) - 1'b1);
    // R10: no command is accepted while busy.
    a_r10_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && wr_busy) |=> (state == ST_CMD || state == ST_IGNORE));
endmodule

// File: tb/serial_ee_slave_test.sv
module serial_ee_slave_test;
    localparam int HP   = 2;
    localparam int BUSY = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sel_n = 1'b1, spi_clk = 1'b0, spi_din = 1'b0;
    logic [8:0] wp_chk_addr = '0;
    logic dout, oe, blk, busy;
    logic dout_s, oe_s, blk_s, busy_s;
    logic [1:0] bp, bp_s;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    serial_ee_slave #(.MEM_BYTES(512), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_clk(spi_clk),
        .spi_din(spi_din), .spi_dout(dout), .spi_dout_oe(oe), .wp_chk_addr(wp_chk_addr),
        .wp_blocked(blk), .wr_busy(busy), .bp_state(bp));
    serial_ee_slave #(.MEM_BYTES(128), .BUSY_CYCLES(BUSY)) uut_small (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_clk(spi_clk),
        .spi_din(spi_din), .spi_dout(dout_s), .spi_dout_oe(oe_s), .wp_chk_addr(wp_chk_addr),
        .wp_blocked(blk_s), .wr_busy(busy_s), .bp_state(bp_s));

    function automatic int exp_byte(input int a);
        int v;
        v = (a * 29 + 7) % 256;
        if (a >= 256) v = v ^ 165;
        return v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic d);
        spi_din = d;
        repeat (HP) @(negedge clk);
        spi_clk = 1'b1;
        repeat (HP) @(negedge clk);
        spi_clk = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) pulse(b[i]);
    endtask

    task automatic sel_low();
        spi_sel_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic sel_high();
        spi_sel_n = 1'b1;
        repeat (HP + 1) @(negedge clk);
    endtask

    // Sequential read on both instances; the small one sees the masked address.
    task automatic read_seq(input int start, input int nbytes);
        logic [7:0] g, gs;
        sel_low();
        send_byte({4'b0000, start[8], 3'b011});
        chk("R3 oe during instruction", int'(oe), 0);
        send_byte(start[7:0]);
        chk("R3 oe at first data bit", int'(oe), 1);
        for (int k = 0; k < nbytes; k++) begin
            for (int b = 7; b >= 0; b--) begin
                g[b] = dout;
                gs[b] = dout_s;
                pulse(1'b0);
            end
            chk("R2 R4 read byte", int'(g), exp_byte((start + k) % 512));
            chk("R5 small read byte", int'(gs), exp_byte(((start % 128) + k) % 128));
        end
        sel_high();
        chk("R3 R6 oe after deselect", int'(oe), 0);
    endtask

    // Status write carrying val, cut or stretched to npulses serial clocks.
    task automatic sr_write(input logic [7:0] val, input int npulses);
        logic [15:0] w;
        w = {8'h01, val};
        sel_low();
        for (int i = 0; i < npulses; i++) pulse(i < 16 ? w[15 - i] : 1'b0);
        spi_sel_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * BUSY && busy; i++) @(negedge clk);
        repeat (HP) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        logic [7:0] g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 oe", int'(oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 bp", int'(bp), 0);

        // R2 R4 R5 address sweep, two bytes per start
        for (int a = 0; a < 512; a += 3) read_seq(a, 2);
        // R4 wrap across the top of both arrays
        read_seq(9'h1F9, 12);

        // R6 deselect in mid-byte, then a fresh read
        sel_low();
        send_byte(8'h03);
        send_byte(8'h10);
        pulse(1'b0);
        pulse(1'b0);
        spi_sel_n = 1'b1;
        repeat (HP + 1) @(negedge clk);
        chk("R6 oe after abort", int'(oe), 0);
        read_seq(9'h020, 1);

        // R12 unknown instruction ignored
        sel_low();
        send_byte(8'h55);
        for (int i = 0; i < 16; i++) begin
            pulse(1'b1);
            chk("R12 oe stays low", int'(oe), 0);
        end
        sel_high();
        read_seq(9'h040, 1);

        // R7 R9 R11 commit each protect value and sweep the checker
        for (int v = 0; v < 4; v++) begin
            sr_write({4'b0000, 2'(v), 2'b00}, 16);
            cnt = 0;
            for (int i = 0; i < 4 * BUSY; i++) begin
                @(negedge clk);
                if (busy) cnt++;
            end
            chk("R9 busy length", cnt, BUSY);
            chk("R7 bp committed", int'(bp), v);
            chk("R7 small bp committed", int'(bp_s), v);
            for (int a = 0; a < 512; a++) begin
                int m;
                wp_chk_addr = 9'(a);
                m = a % 128;
                #1;
                chk("R11 blocked 512", int'(blk),
                    v == 0 ? 0 : v == 1 ? int'(a >= 384) : v == 2 ? int'(a >= 256) : 1);
                chk("R11 blocked 128", int'(blk_s),
                    v == 0 ? 0 : v == 1 ? int'(m >= 96) : v == 2 ? int'(m >= 64) : 1);
            end
        end

        // R8 stretched and short status writes are discarded
        sr_write(8'h00, 17);
        repeat (HP + 2) @(negedge clk);
        chk("R8 17 clocks busy", int'(busy), 0);
        chk("R8 17 clocks bp", int'(bp), 3);
        sr_write(8'h00, 12);
        repeat (HP + 2) @(negedge clk);
        chk("R8 12 clocks busy", int'(busy), 0);
        chk("R8 12 clocks bp", int'(bp), 3);

        // R10 status write during busy is rejected
        sr_write(8'h04, 16);
        repeat (HP + 1) @(negedge clk);
        chk("R9 busy after commit", int'(busy), 1);
        sr_write(8'h08, 16);
        wait_idle();
        chk("R10 bp unchanged by busy write", int'(bp), 1);

        // R10 read during busy is rejected
        sr_write(8'h00, 16);
        repeat (HP + 1) @(negedge clk);
        sel_low();
        send_byte(8'h03);
        send_byte(8'h05);
        for (int i = 0; i < 8; i++) begin
            pulse(1'b0);
            chk("R10 oe during busy read", int'(oe), 0);
        end
        sel_high();
        chk("R7 bp cleared", int'(bp), 0);
        wait_idle();
        read_seq(9'h105, 1);

        // R3 first bit appears right after the address byte
        sel_low();
        send_byte(8'h0B);
        send_byte(8'hFF);
        for (int b = 7; b >= 0; b--) begin
            g[b] = dout;
            pulse(1'b0);
        end
        sel_high();
        chk("R3 top byte", int'(g), exp_byte(511));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule